// File: doc/BRIEF.md
# Unlock-Gated Serial Command Receiver

This block receives commands from a test host over a three-wire synchronous link made of a chip-select level, a host-driven serial clock and one data line. It runs on the chip's own clock: all three lines pass through synchronisers, and edges of the serial clock and of chip select are detected internally. Each session starts when chip select rises. The first eight bits of the session must form an unlock byte. If the byte does not match, the rest of the session is ignored. If it matches, every following group of sixteen bits is handed to the memory controller as a 4-bit opcode and a 12-bit data field, each with a one-cycle valid strobe.

The unlock byte carries an update flag. That flag decides whether the next chip-select rise sends a reload strobe, which tells the memory controller to refresh the live configuration and coefficient registers from non-volatile storage. One reload strobe also follows reset. The block marks the start and the end of an unlocked session with pulses. It drives an output-enable level for the analog output and a direction level for the shared data pin, which turns to output once a read command has been received.

Top module: `sercmd_rx`

## Requirements
- R1: After a chip-select rise, the first eight sampled bits (first bit = MSB) unlock the session only if they equal 1,0,1,0,1,0,U,0 (A8h or AAh). A match gives exactly one one-cycle `comm_start` pulse.
- R2: If the first eight bits do not match, no word is issued and no start pulse appears for the rest of that session. A later chip-select rise followed by a good unlock byte works normally.
- R3: After unlock, each group of 16 bits, MSB first, gives one `word_valid` pulse exactly one clock long. `word_op` holds bits 15..12 and `word_data` holds bits 11..0.
- R4: A word that is only partly received when chip select falls is dropped and never issued.
- R5: If the last accepted unlock had U=0 (or no unlock has been accepted since reset), the next chip-select rise gives one `reload_strobe` pulse. After an unlock with U=1, chip-select rises give no reload strobe until an unlock with U=0 is accepted.
- R6: After reset, `word_valid`, `comm_start`, `comm_end`, `dio_drive` and `out_en` are low, and exactly one `reload_strobe` pulse is produced for the power-up reload.
- R7: `out_en` follows the synchronised chip-select level. When chip select falls after an unlocked session, one `comm_end` pulse is produced. A session that was never unlocked gives no `comm_end`.
- R8: Receiving opcode 3 (read one bit) or opcode 4 (read whole array) drives `dio_drive` high. It stays high until chip select falls, and then returns low.
- R9: Serial clock edges while chip select is low produce no word, no start pulse and no end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel | input | 1 | Chip select, high = session active (asynchronous) |
| sclk | input | 1 | Host serial clock (asynchronous) |
| dio_in | input | 1 | Serial data from host, sampled on serial clock rise |
| word_valid | output | 1 | One-cycle strobe for a completed command word |
| word_op | output | 4 | Opcode field of the last word |
| word_data | output | 12 | Data field of the last word |
| reload_strobe | output | 1 | One-cycle request to reload live registers from storage |
| comm_start | output | 1 | One-cycle pulse on a successful unlock |
| comm_end | output | 1 | One-cycle pulse when an unlocked session closes |
| dio_drive | output | 1 | High when the data pin should be driven as an output |
| out_en | output | 1 | Analog output enable (low = high impedance) |

## Verification
The bench sends unlock bytes that differ from the pattern only in the last bit or the first bit. A matcher that masked the wrong bits would accept them and issue the words that follow. It ends a session in the middle of a word. A receiver that kept its bit count across sessions would then emit a corrupted word or shift later words out of alignment. It follows the update flag over several sessions, including one that never unlocks. A flag that was cleared by every chip-select rise, or read at the wrong moment, would drop the reload or give an extra one. It also toggles the serial clock with chip select low and checks that the read direction clears when chip select falls, because a design that gated either of these wrongly shows stray words or a data pin left driven.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int OP_W     = 4;
    localparam int DATA_W   = 12;
    localparam int WORD_W   = OP_W + DATA_W;
    localparam int UNLOCK_W = 8;

    localparam int IDX_CS   = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_DIO  = 2;
    localparam int N_LINES  = 3;

    localparam logic [UNLOCK_W-1:0] UNLOCK_PAT  = 8'hA8;
    localparam logic [UNLOCK_W-1:0] UNLOCK_MASK = 8'hFD;

    localparam logic [OP_W-1:0] OP_NOP   = 4'h0;
    localparam logic [OP_W-1:0] OP_ERASE = 4'h1;
    localparam logic [OP_W-1:0] OP_WRBIT = 4'h2;
    localparam logic [OP_W-1:0] OP_RDBIT = 4'h3;
    localparam logic [OP_W-1:0] OP_RDALL = 4'h4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_LOCK,
        ST_REJECT
    } rx_state_t;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] data;
    } cmd_word_t;

    function automatic logic unlock_ok(input logic [UNLOCK_W-1:0] b);
        return (b & UNLOCK_MASK) == UNLOCK_PAT;
    endfunction

    function automatic logic is_read_op(input logic [OP_W-1:0] op);
        return (op == OP_RDBIT) || (op == OP_RDALL);
    endfunction

endpackage

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/sercmd_deser.sv
module sercmd_deser
    import sercmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_level,
    input  logic      cs_rise,
    input  logic      bit_strobe,
    input  logic      bit_val,
    output logic      word_valid,
    output cmd_word_t word,
    output logic      comm_start,
    output logic      u_flag,
    output logic      comm_end,
    output logic      dio_drive
);
    localparam int CNT_W = $clog2(WORD_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] nxt;

    assign nxt = {sh[WORD_W-2:0], bit_val};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            sh         <= '0;
            word_valid <= 1'b0;
            word       <= '0;
            comm_start <= 1'b0;
            u_flag     <= 1'b0;
            comm_end   <= 1'b0;
            dio_drive  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            comm_start <= 1'b0;
            comm_end   <= 1'b0;
            if (!cs_level) begin
                comm_end  <= (state == ST_LOCK);
                state     <= ST_IDLE;
                cnt       <= '0;
                dio_drive <= 1'b0;
            end else if (cs_rise) begin
                state <= ST_HUNT;
                cnt   <= '0;
            end else if (bit_strobe) begin
                case (state)
                    ST_HUNT: begin
                        sh <= nxt;
                        if (cnt == CNT_W'(UNLOCK_W - 1)) begin
                            cnt <= '0;
                            if (unlock_ok(nxt[UNLOCK_W-1:0])) begin
                                state      <= ST_LOCK;
                                comm_start <= 1'b1;
                                u_flag     <= nxt[1];
                            end else begin
                                state <= ST_REJECT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_LOCK: begin
                        sh <= nxt;
                        if (cnt == CNT_W'(WORD_W - 1)) begin
                            cnt        <= '0;
                            word_valid <= 1'b1;
                            word       <= cmd_word_t'(nxt);
                            if (is_read_op(nxt[WORD_W-1 -: OP_W])) dio_drive <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r3_valid_single: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    a_r2_reject_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT) |-> !word_valid);
    a_r9_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
        !cs_level |=> (!word_valid && !comm_start));
    a_r1_start_pulse: assert property (@(posedge clk) disable iff (rst)
        comm_start |=> !comm_start);
endmodule

// File: rtl/sercmd_reload.sv
module sercmd_reload (
    input  logic clk,
    input  logic rst,
    input  logic cs_rise,
    input  logic unlock_seen,
    input  logic u_flag,
    output logic reload_strobe
);
    logic pwr_pending;
    logic reload_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_pending   <= 1'b1;
            reload_next   <= 1'b1;
            reload_strobe <= 1'b0;
        end else begin
            pwr_pending   <= 1'b0;
            reload_strobe <= pwr_pending | (cs_rise & reload_next);
            if (unlock_seen) reload_next <= ~u_flag;
        end
    end

    a_r5_reload_single: assert property (@(posedge clk) disable iff (rst)
        reload_strobe |=> !reload_strobe);
endmodule

// File: rtl/sercmd_rx.sv
module sercmd_rx
    import sercmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_sel,
    input  logic              sclk,
    input  logic              dio_in,
    output logic              word_valid,
    output logic [OP_W-1:0]   word_op,
    output logic [DATA_W-1:0] word_data,
    output logic              reload_strobe,
    output logic              comm_start,
    output logic              comm_end,
    output logic              dio_drive,
    output logic              out_en
);
    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl;
    logic               cs_prev;
    logic               sclk_prev;
    logic               cs_rise;
    logic               sclk_rise;
    logic               u_flag;
    cmd_word_t          word;

    always_comb begin
        raw           = '0;
        raw[IDX_CS]   = cs_sel;
        raw[IDX_SCLK] = sclk;
        raw[IDX_DIO]  = dio_in;
    end

    sercmd_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(raw), .sync_out(lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev   <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= lvl[IDX_CS];
            sclk_prev <= lvl[IDX_SCLK];
        end
    end

    assign cs_rise   = lvl[IDX_CS] & ~cs_prev;
    assign sclk_rise = lvl[IDX_SCLK] & ~sclk_prev;

    sercmd_deser u_deser (
        .clk(clk), .rst(rst),
        .cs_level(lvl[IDX_CS]), .cs_rise(cs_rise),
        .bit_strobe(sclk_rise), .bit_val(lvl[IDX_DIO]),
        .word_valid(word_valid), .word(word),
        .comm_start(comm_start), .u_flag(u_flag),
        .comm_end(comm_end), .dio_drive(dio_drive)
    );

    sercmd_reload u_reload (
        .clk(clk), .rst(rst), .cs_rise(cs_rise),
        .unlock_seen(comm_start), .u_flag(u_flag),
        .reload_strobe(reload_strobe)
    );

    assign word_op   = word.op;
    assign word_data = word.data;
    assign out_en    = lvl[IDX_CS];

    a_r8_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
        dio_drive |-> (out_en || $past(out_en)));
    a_r7_end_after_drop: assert property (@(posedge clk) disable iff (rst)
        comm_end |-> !out_en);
endmodule

// File: tb/sercmd_rx_tb.sv
module sercmd_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_sel = 1'b0;
    logic        sclk = 1'b0;
    logic        dio_in = 1'b0;
    logic        word_valid;
    logic [3:0]  word_op;
    logic [11:0] word_data;
    logic        reload_strobe;
    logic        comm_start;
    logic        comm_end;
    logic        dio_drive;
    logic        out_en;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_reload = 0, n_start = 0, n_end = 0, run = 0, max_run = 0;
    logic [3:0]  last_op = '0;
    logic [11:0] last_data = '0;
    bit done = 1'b0;

    localparam logic [31:0] VEC [6] = '{
        {16'h001C, 4'h0, 12'h01C},
        {16'h201C, 4'h2, 12'h01C},
        {16'h1000, 4'h1, 12'h000},
        {16'hF123, 4'hF, 12'h123},
        {16'h5AAA, 4'h5, 12'hAAA},
        {16'h0FFF, 4'h0, 12'hFFF}
    };

    always #10 clk = ~clk;

    sercmd_rx u_dut (
        .clk(clk), .rst(rst), .cs_sel(cs_sel), .sclk(sclk), .dio_in(dio_in),
        .word_valid(word_valid), .word_op(word_op), .word_data(word_data),
        .reload_strobe(reload_strobe), .comm_start(comm_start),
        .comm_end(comm_end), .dio_drive(dio_drive), .out_en(out_en)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (word_valid) begin
                n_valid++;
                last_op   = word_op;
                last_data = word_data;
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            if (reload_strobe) n_reload++;
            if (comm_start) n_start++;
            if (comm_end) n_end++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        dio_in = b;
        wait_n(8);
        sclk = 1'b1;
        wait_n(8);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic cs_up();
        cs_sel = 1'b1;
        wait_n(8);
    endtask

    task automatic cs_down();
        cs_sel = 1'b0;
        wait_n(8);
    endtask

    initial begin
        int v0, r0, s0, e0;
        wait_n(5);
        rst = 1'b0;
        wait_n(10);

        // reset state and power-up reload
        check(n_reload == 1, "R6 power-up reload", n_reload, 1);
        check(!word_valid && !comm_start && !comm_end, "R6 idle strobes", word_valid, 0);
        check(!dio_drive && !out_en, "R6 drive/enable low", {dio_drive, out_en}, 0);

        // session 1: default flag gives reload, unlock AA (U=1)
        r0 = n_reload;
        cs_up();
        check(n_reload == r0 + 1, "R5 reload default flag", n_reload - r0, 1);
        check(out_en == 1'b1, "R7 out_en follows cs", out_en, 1);
        send_bits(16'h00AA, 8);
        check(n_start == 1, "R1 unlock AA", n_start, 1);
        for (int k = 0; k < 6; k++) begin
            v0 = n_valid;
            send_bits(VEC[k][31:16], 16);
            check(n_valid == v0 + 1, "R3 word count", n_valid - v0, 1);
            check(last_op == VEC[k][15:12], "R3 opcode", last_op, VEC[k][15:12]);
            check(last_data == VEC[k][11:0], "R3 data", last_data, VEC[k][11:0]);
        end
        check(max_run == 1, "R3 valid width", max_run, 1);
        check(dio_drive == 1'b0, "R8 no read yet", dio_drive, 0);
        v0 = n_valid;
        send_bits(16'h01FF, 9);
        cs_down();
        check(n_valid == v0, "R4 partial dropped", n_valid - v0, 0);
        check(n_end == 1, "R7 end pulse", n_end, 1);
        check(out_en == 1'b0, "R7 out_en low", out_en, 0);

        // session 2: U=1 blocks reload; unlock A8; read bit command
        r0 = n_reload;
        cs_up();
        check(n_reload == r0, "R5 no reload after U=1", n_reload - r0, 0);
        v0 = n_valid;
        send_bits(16'h00A8, 8);
        check(n_start == 2, "R1 unlock A8", n_start, 2);
        send_bits(16'h3005, 16);
        check(n_valid == v0 + 1 && last_op == 4'h3, "R3 read word issued", last_op, 3);
        check(dio_drive == 1'b1, "R8 read bit drives", dio_drive, 1);
        cs_down();
        check(dio_drive == 1'b0, "R8 drive clears on cs low", dio_drive, 0);

        // session 3: U=0 gives reload; bad byte A9 (last bit wrong)
        r0 = n_reload; s0 = n_start; e0 = n_end; v0 = n_valid;
        cs_up();
        check(n_reload == r0 + 1, "R5 reload after U=0", n_reload - r0, 1);
        send_bits(16'h00A9, 8);
        check(n_start == s0, "R1 A9 rejected", n_start - s0, 0);
        send_bits(16'h2001, 16);
        send_bits(16'h00A8, 8);
        send_bits(16'h1000, 16);
        check(n_valid == v0, "R2 words ignored", n_valid - v0, 0);
        cs_down();
        check(n_end == e0, "R7 no end without unlock", n_end - e0, 0);

        // session 4: flag still from U=0; bad byte 2A (first bit wrong)
        r0 = n_reload; s0 = n_start;
        cs_up();
        check(n_reload == r0 + 1, "R5 flag persists", n_reload - r0, 1);
        send_bits(16'h002A, 8);
        check(n_start == s0, "R1 2A rejected", n_start - s0, 0);
        cs_down();

        // serial clock with cs low
        s0 = n_start; e0 = n_end; v0 = n_valid;
        send_bits(16'h00A8, 8);
        send_bits(16'h2055, 16);
        check(n_valid == v0 && n_start == s0 && n_end == e0, "R9 ignored while deselected",
              n_valid - v0, 0);

        // session 5: recovery after reject, read whole array opcode
        cs_up();
        send_bits(16'h00A8, 8);
        check(n_start == s0 + 1, "R2 recovery unlock", n_start - s0, 1);
        send_bits(16'h4ABC, 16);
        check(n_valid == v0 + 1 && last_data == 12'hABC, "R3 word after recovery", last_data, 12'hABC);
        check(dio_drive == 1'b1, "R8 read array drives", dio_drive, 1);
        cs_down();
        check(n_end == e0 + 1, "R7 end after session", n_end - e0, 1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule